// File: doc/BRIEF.md
# Flash Command Sequencer with Status

This block sits between a CPU bus and an embedded flash array while software rewrites the flash. It decodes the byte of each accepted bus write as a command and keeps a read mode that persists between commands. The mode decides what a bus read returns. In array mode a read returns the byte stored at the read address. In status mode a read returns an 8-bit status byte. The status byte carries a ready bit and a sticky program-error bit.

A program operation takes two write cycles. The first write carries the program command byte. The second write carries the target address and the data byte. When the second write is accepted, the block does four things: it drives a one-cycle request to the array model, marks itself busy, drops the ready flag and switches reads to status output. The array answers with a done pulse and a fail flag. Programming pulses and verify circuitry are outside this block. The behavioural array model in the bench stands in for them and answers after a fixed latency.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array mode with `ready` = 1. A status read in this state returns 0x80.
- R2: Writing 0xFF selects array mode. `rd_data` then equals `arr_rd_data`, which the array returns for `arr_rd_addr` = `rd_addr`.
- R3: Writing 0x70 selects status mode. `rd_data` then shows the status byte: bit 7 is ready, bit 4 is program error, bit 5 is erase error (always 0 here), and bits 6 and 3..0 read 0.
- R4: Writing 0x40 arms a program sequence. The next accepted write starts programming: `prog_req` is high for exactly the one cycle after that write edge, with `prog_addr`/`prog_data` holding that write's address and data.
- R5: When programming starts the block enters status mode by itself. Reads return the status byte until a later command changes the mode.
- R6: `ready` and status bit 7 are 0 from the cycle after the start write until `prog_done` is seen, and 1 from the cycle after that.
- R7: A `prog_done` with `prog_fail` = 1 sets status bit 4. The bit stays set until a clear command.
- R8: Writing 0x50 clears status bits 4 and 5 and leaves the read mode unchanged. It is accepted even while busy.
- R9: While `rewrite_en` is 0, bus writes have no effect.
- R10: While busy, every write other than 0x50 is ignored.
- R11: An unrecognised command byte leaves the mode unchanged and sets no status bit.
- R12: The read mode persists across any number of reads and address changes until another command is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rewrite_en | input | 1 | Rewrite mode enable; writes are ignored when 0 |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | AW | Bus write address |
| wr_data | input | 8 | Bus write data / command byte |
| rd_addr | input | AW | Bus read address |
| rd_data | output | 8 | Bus read data (array byte or status byte) |
| arr_rd_addr | output | AW | Read address to the flash array |
| arr_rd_data | input | 8 | Read data from the flash array |
| prog_req | output | 1 | One-cycle program request to the array |
| prog_addr | output | AW | Program target address |
| prog_data | output | 8 | Program data byte |
| prog_done | input | 1 | Program completion pulse from the array |
| prog_fail | input | 1 | Program result, valid with `prog_done` |
| ready | output | 1 | 1 when idle, 0 while programming |

## Verification
The sequencer is driven with several kinds of write: plain mode commands, the two-cycle program sequence, unknown bytes, writes while rewrite is disabled, and writes during a busy window. Comparing the read byte after each kind shows whether the mode changed or stayed. Programs that pass and programs that fail the array's verify are mixed, with a clear issued both while idle and while busy. Together these separate sticky error handling from ready timing. Every clock the bench also compares `rd_data`, `ready` and `prog_req` against a behavioural model, which exposes off-by-one busy timing.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic {
    MODE_ARRAY  = 1'b0,
    MODE_STATUS = 1'b1
  } rd_mode_e;

  localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
  localparam logic [7:0] CMD_PROGRAM      = 8'h40;

  localparam int SR_READY_BIT    = 7;
  localparam int SR_ERASE_ERR_BIT = 5;
  localparam int SR_PROG_ERR_BIT = 4;

  typedef struct packed {
    logic to_array;
    logic to_status;
    logic clear_err;
    logic arm_prog;
    logic start_prog;
  } cmd_ev_t;

  function automatic logic [7:0] pack_status(input logic busy,
                                             input logic prog_err,
                                             input logic erase_err);
    logic [7:0] s;
    s = 8'h00;
    s[SR_READY_BIT]     = ~busy;
    s[SR_ERASE_ERR_BIT] = erase_err;
    s[SR_PROG_ERR_BIT]  = prog_err;
    return s;
  endfunction

endpackage

// File: rtl/fcs_decoder.sv
module fcs_decoder
  import flash_cmd_pkg::*;
(
  input  logic       wr_accept,
  input  logic [7:0] wr_data,
  input  logic       busy,
  input  logic       armed,
  output cmd_ev_t    ev
);

  always_comb begin
    ev = '0;
    if (wr_accept) begin
      if (busy) begin
        ev.clear_err = (wr_data == CMD_CLEAR_STATUS);
      end else if (armed) begin
        ev.start_prog = 1'b1;
      end else begin
        unique case (wr_data)
          CMD_READ_ARRAY:   ev.to_array  = 1'b1;
          CMD_READ_STATUS:  ev.to_status = 1'b1;
          CMD_CLEAR_STATUS: ev.clear_err = 1'b1;
          CMD_PROGRAM:      ev.arm_prog  = 1'b1;
          default:          ev = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/fcs_mode.sv
module fcs_mode
  import flash_cmd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_ev_t       ev,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output rd_mode_e      mode,
  output logic          armed,
  output logic          prog_req,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MODE_ARRAY;
      armed     <= 1'b0;
      prog_req  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      prog_req <= ev.start_prog;
      if (ev.to_array)  mode <= MODE_ARRAY;
      if (ev.to_status) mode <= MODE_STATUS;
      if (ev.arm_prog)  armed <= 1'b1;
      if (ev.start_prog) begin
        armed     <= 1'b0;
        mode      <= MODE_STATUS;
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end

endmodule

// File: rtl/fcs_status.sv
module fcs_status
  import flash_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cmd_ev_t ev,
  input  logic    prog_done,
  input  logic    prog_fail,
  output logic    busy,
  output logic    prog_err,
  output logic    done_evt
);

  assign done_evt = prog_done & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      prog_err <= 1'b0;
    end else begin
      if (ev.start_prog) busy <= 1'b1;
      if (ev.clear_err)  prog_err <= 1'b0;
      if (done_evt) begin
        busy     <= 1'b0;
        prog_err <= prog_err | prog_fail;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rewrite_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [AW-1:0] arr_rd_addr,
  input  logic [7:0]    arr_rd_data,
  output logic          prog_req,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  input  logic          prog_done,
  input  logic          prog_fail,
  output logic          ready
);

  cmd_ev_t    ev;
  rd_mode_e   mode;
  logic       armed;
  logic       busy;
  logic       prog_err;
  logic       done_evt;
  logic       wr_accept;
  logic       start_prog;
  logic       mode_status;
  logic [7:0] status_byte;

  assign wr_accept   = rewrite_en & wr_en;
  assign start_prog  = ev.start_prog;
  assign mode_status = (mode == MODE_STATUS);
  assign status_byte = pack_status(busy, prog_err, 1'b0);

  fcs_decoder u_dec (
    .wr_accept (wr_accept),
    .wr_data   (wr_data),
    .busy      (busy),
    .armed     (armed),
    .ev        (ev)
  );

  fcs_mode #(.AW(AW)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mode      (mode),
    .armed     (armed),
    .prog_req  (prog_req),
    .prog_addr (prog_addr),
    .prog_data (prog_data)
  );

  fcs_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .prog_done (prog_done),
    .prog_fail (prog_fail),
    .busy      (busy),
    .prog_err  (prog_err),
    .done_evt  (done_evt)
  );

  assign arr_rd_addr = rd_addr;
  assign rd_data     = mode_status ? status_byte : arr_rd_data;
  assign ready       = ~busy;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rewrite_en,
  input logic       wr_en,
  input logic       start_prog,
  input logic       done_evt,
  input logic       prog_fail,
  input logic       prog_req,
  input logic       ready,
  input logic       mode_status,
  input logic [7:0] status_byte
);

  // R6
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |=> !ready);

  // R6
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> ready);

  // R4
  req_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |=> prog_req);

  // R4
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  // R5
  status_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |=> mode_status);

  // R7
  fail_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && prog_fail) |=> status_byte[4]);

  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rewrite_en && wr_en) |=> $stable(mode_status));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && wr_en) |=> $stable(mode_status));

endmodule

bind flash_cmd_seq fcs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rewrite_en  (rewrite_en),
  .wr_en       (wr_en),
  .start_prog  (start_prog),
  .done_evt    (done_evt),
  .prog_fail   (prog_fail),
  .prog_req    (prog_req),
  .ready       (ready),
  .mode_status (mode_status),
  .status_byte (status_byte)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

  localparam int AW  = 8;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rewrite_en = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = 8'h21;
  logic [7:0]    rd_data;
  logic [AW-1:0] arr_rd_addr;
  logic [7:0]    arr_rd_data;
  logic          prog_req;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic          prog_done = 1'b0;
  logic          prog_fail = 1'b0;
  logic          ready;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mem [256];

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.AW(AW)) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .rewrite_en(rewrite_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_done(prog_done),
    .prog_fail(prog_fail), .ready(ready)
  );

  assign arr_rd_data = mem[arr_rd_addr];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural array model: flash-like programming (bits only clear)
  int          cnt = 0;
  logic [7:0]  p_a, p_d;
  always @(negedge clk) begin
    prog_done = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        prog_fail = ((mem[p_a] & p_d) != p_d);
        mem[p_a]  = mem[p_a] & p_d;
        prog_done = 1'b1;
      end
    end else if (prog_req) begin
      cnt = LAT;
      p_a = prog_addr;
      p_d = prog_data;
    end
  end

  // reference model
  bit m_status, m_busy, m_err, m_armed, m_req;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_status = 0; m_busy = 0; m_err = 0; m_armed = 0; m_req = 0;
    end else begin
      bit ob, oe;
      ob = m_busy; oe = m_err;
      m_req = 0;
      if (rewrite_en && wr_en) begin
        if (ob) begin
          if (wr_data == 8'h50) m_err = 0;
        end else if (m_armed) begin
          m_armed = 0; m_busy = 1; m_status = 1; m_req = 1;
        end else begin
          case (wr_data)
            8'hFF: m_status = 0;
            8'h70: m_status = 1;
            8'h50: m_err = 0;
            8'h40: m_armed = 1;
            default: ;
          endcase
        end
      end
      if (prog_done && ob) begin
        m_busy = 0;
        m_err  = oe | prog_fail;
      end
    end
  end

  function automatic logic [7:0] exp_status();
    return {~m_busy, 2'b00, m_err, 4'b0000};
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      logic [7:0] e;
      e = m_status ? exp_status() : mem[rd_addr];
      chk(rd_data == e, "R2/R3/R5 model rd_data", rd_data, e);
      chk(ready == !m_busy, "R6 model ready", ready, !m_busy);
      chk(prog_req == m_req, "R4 model prog_req", prog_req, m_req);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    #2;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 50; i++) begin
      if (ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 29) ^ 8'h5A);
    mem[8'h10] = 8'hFF;
    mem[8'h20] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    #2;
    // R1
    chk(ready == 1, "R1 ready after reset", ready, 1);
    chk(rd_data == mem[8'h21], "R1 array mode after reset", rd_data, mem[8'h21]);
    wr(8'h00, 8'h70);
    chk(rd_data == 8'h80, "R1/R3 idle status", rd_data, 8'h80);
    rd_addr = 8'h77; #1;
    chk(rd_data == 8'h80, "R12 status kept across reads", rd_data, 8'h80);
    wr(8'h00, 8'h12);
    chk(rd_data == 8'h80, "R11 unknown byte in status mode", rd_data, 8'h80);
    wr(8'h00, 8'hFF);
    chk(rd_data == mem[8'h77], "R2 array read", rd_data, mem[8'h77]);
    rd_addr = 8'h21; #1;
    chk(rd_data == mem[8'h21], "R12 array kept across reads", rd_data, mem[8'h21]);
    wr(8'h00, 8'h33);
    chk(rd_data == mem[8'h21], "R11 unknown byte in array mode", rd_data, mem[8'h21]);
    rewrite_en = 0;
    wr(8'h00, 8'h70);
    chk(rd_data == mem[8'h21], "R9 write ignored when disabled", rd_data, mem[8'h21]);
    rewrite_en = 1;

    // successful program
    wr(8'h00, 8'h40);
    chk(rd_data == mem[8'h21], "R4 arm keeps mode", rd_data, mem[8'h21]);
    wr(8'h10, 8'h3C);
    chk(ready == 0, "R6 busy after start", ready, 0);
    chk(prog_req == 1 && prog_addr == 8'h10 && prog_data == 8'h3C,
        "R4 program request", {prog_req, prog_addr, prog_data}, {1'b1, 8'h10, 8'h3C});
    chk(rd_data == 8'h00, "R5 auto status while busy", rd_data, 8'h00);
    wr(8'h00, 8'hFF);
    chk(rd_data == 8'h00, "R10 command ignored while busy", rd_data, 8'h00);
    wait_ready();
    chk(rd_data == 8'h80, "R6 ready after done", rd_data, 8'h80);
    chk(mem[8'h10] == 8'h3C, "R4 array programmed", mem[8'h10], 8'h3C);

    // failing program
    wr(8'h00, 8'h40);
    wr(8'h10, 8'hC3);
    wait_ready();
    chk(rd_data == 8'h90, "R7 error after failed program", rd_data, 8'h90);
    wr(8'h00, 8'hFF);
    wr(8'h00, 8'h70);
    chk(rd_data == 8'h90, "R7 error sticky", rd_data, 8'h90);
    wr(8'h00, 8'h50);
    chk(rd_data == 8'h80, "R8 clear keeps status mode", rd_data, 8'h80);

    // clear while busy
    wr(8'h00, 8'h40);
    wr(8'h10, 8'hC3);
    wait_ready();
    chk(rd_data == 8'h90, "R7 error set again", rd_data, 8'h90);
    wr(8'h00, 8'h40);
    wr(8'h20, 8'h01);
    chk(rd_data == 8'h10, "R6 busy with error kept", rd_data, 8'h10);
    wr(8'h00, 8'h50);
    chk(rd_data == 8'h00, "R8 clear accepted while busy", rd_data, 8'h00);
    wait_ready();
    chk(rd_data == 8'h80, "R8 clean finish", rd_data, 8'h80);
    rd_addr = 8'h20;
    wr(8'h00, 8'hFF);
    chk(rd_data == 8'h01, "R2 programmed byte readable", rd_data, 8'h01);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule